// File: doc/BRIEF.md
# Packet Handler Dispatch Lookup

This block decides which handler slot receives each incoming packet. As soon as the header parser has extracted the protocol number, destination IPv4 address and destination port, the block compares them against a small rule table. All rules are compared at once. The outcome is a hit flag and a slot number. That outcome is pushed into a result queue straight away. The lookup therefore runs while the packet is still in core protocol processing.

When core processing of a packet finishes, a completion strobe pulls the oldest queued outcome. The packet is then either sent to its slot or discarded. It is discarded when no rule matched, or when the input buffer of the chosen slot reports full. Packets are neither reordered nor skipped between lookup and delivery, so a plain first-in first-out queue pairs each outcome with its packet. A management write port loads one rule per cycle. The queue pushes back on the header input when it is full.

Top module: `pkt_dispatch_lookup`

## Requirements
- R1: After reset, `hdr_ready` is 1 and `fwd_valid` and `drop_valid` are 0.
- R2: A rule matches a header when its valid bit is set, its protocol equals `hdr_proto`, its port equals `hdr_dst_port`, and its address equals `hdr_dst_ip` on every bit where the rule's mask is 1.
- R3: A mask with zeros in its low bits lets one rule cover a whole subnet, so any host address inside that subnet matches the rule.
- R4: When several rules match, the rule with the lowest index decides the slot.
- R5: Every rule is invalid after reset. A rule written with `cfg_valid` = 0 never matches.
- R6: A header that matches no rule produces, on completion, `drop_valid` = 1 with `drop_reason` = 0 and no forward.
- R7: A header whose matched slot has its `slot_full` bit set at completion produces `drop_valid` = 1 with `drop_reason` = 1. If that bit is clear, it produces `fwd_valid` = 1 with `fwd_slot` equal to the rule's slot.
- R8: Outcomes are delivered in the order headers were accepted. Each outcome reflects the table as it stood when its header was accepted, whatever is written to the table afterwards.
- R9: With FIFO_DEPTH outcomes queued, `hdr_ready` is 0, and a header presented while `hdr_ready` is 0 is not queued.
- R10: A `done_valid` pulse with no queued outcome produces neither `fwd_valid` nor `drop_valid`.
- R11: A rule written on a clock edge affects headers accepted on later edges but not a header accepted on that same edge.
- R12: For each completion there is exactly one of `fwd_valid` and `drop_valid`, one cycle after the `done_valid` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Rule write strobe |
| cfg_idx | input | $clog2(N_ENTRIES) | Index of the rule written |
| cfg_valid | input | 1 | Valid bit of the rule written |
| cfg_proto | input | 8 | Rule protocol number |
| cfg_addr | input | 32 | Rule destination address |
| cfg_mask | input | 32 | Rule address mask, 1 = bit compared |
| cfg_port | input | 16 | Rule destination port |
| cfg_slot | input | $clog2(NUM_SLOTS) | Handler slot of the rule |
| hdr_valid | input | 1 | Header fields present |
| hdr_ready | output | 1 | Result queue can take a header |
| hdr_proto | input | 8 | Header protocol number |
| hdr_dst_ip | input | 32 | Header destination address |
| hdr_dst_port | input | 16 | Header destination port |
| done_valid | input | 1 | Oldest packet finished core processing |
| slot_full | input | NUM_SLOTS | Per-slot input buffer full flags |
| fwd_valid | output | 1 | Packet forwarded this cycle |
| fwd_slot | output | $clog2(NUM_SLOTS) | Slot the packet is forwarded to |
| drop_valid | output | 1 | Packet discarded this cycle |
| drop_reason | output | 1 | 0 = no rule matched, 1 = slot buffer full |

## Verification
A header is looked up on the edge that accepts it, so a rule write on that edge is not seen and the bench checks this by driving both at once. The delivery outcome is registered, so it appears one cycle after the edge that samples `done_valid`. `slot_full` is sampled on that same edge. The bench drives every stimulus just after a falling edge and reads the outputs at the next falling edge, half a cycle after the register updates. Expected outcomes are computed when a header is accepted and held in the bench's own queue. This checks ordering and late table changes without looking inside the design.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  localparam int PROTO_W = 8;
  localparam int ADDR_W  = 32;
  localparam int PORT_W  = 16;

  typedef struct packed {
    logic [PROTO_W-1:0] proto;
    logic [ADDR_W-1:0]  addr;
    logic [PORT_W-1:0]  port;
  } hdr_key_t;

  // One rule against one probe: exact protocol and port, address compared under mask
  function automatic logic key_match(hdr_key_t rule, logic [ADDR_W-1:0] mask, hdr_key_t probe);
    return (rule.proto == probe.proto) &&
           (((rule.addr ^ probe.addr) & mask) == '0) &&
           (rule.port == probe.port);
  endfunction
endpackage

// File: rtl/pdl_route_table.sv
module pdl_route_table import pdl_pkg::*; #(
  parameter int N_ENTRIES = 16,
  parameter int SLOT_W    = 3,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  hdr_key_t          wr_key,
  input  logic [ADDR_W-1:0] wr_mask,
  input  logic [SLOT_W-1:0] wr_slot,
  input  hdr_key_t          probe,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [N_ENTRIES-1:0] ent_valid;
  hdr_key_t             ent_key  [N_ENTRIES];
  logic [ADDR_W-1:0]    ent_mask [N_ENTRIES];
  logic [SLOT_W-1:0]    ent_slot [N_ENTRIES];
  logic [N_ENTRIES-1:0] match_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) ent_valid <= '0;
    else if (wr_en) ent_valid[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_key[wr_idx]  <= wr_key;
      ent_mask[wr_idx] <= wr_mask;
      ent_slot[wr_idx] <= wr_slot;
    end
  end

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = ent_valid[g] && key_match(ent_key[g], ent_mask[g], probe);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--)
      if (match_vec[i]) hit_idx = IDX_W'(i);
    hit      = |match_vec;
    hit_slot = ent_slot[hit_idx];
  end

  // R4
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((match_vec & ((N_ENTRIES'(1) << hit_idx) - N_ENTRIES'(1))) == '0));
  // R5
  valid_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ent_valid[hit_idx]);
endmodule

// File: rtl/pdl_result_fifo.sv
module pdl_result_fifo #(
  parameter int DEPTH   = 4,
  parameter int WIDTH   = 4,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (full && $stable(wr_ptr)));
  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (empty && $stable(rd_ptr)));
endmodule

// File: rtl/pkt_dispatch_lookup.sv
module pkt_dispatch_lookup import pdl_pkg::*; #(
  parameter int N_ENTRIES  = 16,
  parameter int NUM_SLOTS  = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int IDX_W     = $clog2(N_ENTRIES),
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_valid,
  input  logic [PROTO_W-1:0] cfg_proto,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [ADDR_W-1:0]  cfg_mask,
  input  logic [PORT_W-1:0]  cfg_port,
  input  logic [SLOT_W-1:0]  cfg_slot,
  input  logic               hdr_valid,
  output logic               hdr_ready,
  input  logic [PROTO_W-1:0] hdr_proto,
  input  logic [ADDR_W-1:0]  hdr_dst_ip,
  input  logic [PORT_W-1:0]  hdr_dst_port,
  input  logic               done_valid,
  input  logic [NUM_SLOTS-1:0] slot_full,
  output logic               fwd_valid,
  output logic [SLOT_W-1:0]  fwd_slot,
  output logic               drop_valid,
  output logic               drop_reason
);
  hdr_key_t          probe, rule_key;
  logic              lk_hit;
  logic [SLOT_W-1:0] lk_slot;
  logic [IDX_W-1:0]  lk_idx;
  logic              q_full, q_empty;
  logic              head_hit;
  logic [SLOT_W-1:0] head_slot;
  logic              pop, head_blocked;

  assign probe    = '{proto: hdr_proto, addr: hdr_dst_ip, port: hdr_dst_port};
  assign rule_key = '{proto: cfg_proto, addr: cfg_addr, port: cfg_port};

  pdl_route_table #(.N_ENTRIES(N_ENTRIES), .SLOT_W(SLOT_W)) table_i (
    .clk, .rst_n,
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_valid(cfg_valid),
    .wr_key(rule_key), .wr_mask(cfg_mask), .wr_slot(cfg_slot),
    .probe, .hit(lk_hit), .hit_slot(lk_slot), .hit_idx(lk_idx)
  );

  pdl_result_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(SLOT_W + 1)) queue_i (
    .clk, .rst_n,
    .push(hdr_valid), .push_data({lk_hit, lk_slot}),
    .pop(done_valid), .pop_data({head_hit, head_slot}),
    .full(q_full), .empty(q_empty)
  );

  assign hdr_ready    = !q_full;
  assign pop          = done_valid && !q_empty;
  assign head_blocked = slot_full[head_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid   <= 1'b0;
      fwd_slot    <= '0;
      drop_valid  <= 1'b0;
      drop_reason <= 1'b0;
    end else begin
      fwd_valid   <= pop && head_hit && !head_blocked;
      fwd_slot    <= head_slot;
      drop_valid  <= pop && (!head_hit || head_blocked);
      drop_reason <= head_hit;
    end
  end

  // R12
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_valid, drop_valid}));
  // R7
  fwd_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && head_hit && !slot_full[head_slot]) |=> (fwd_valid && fwd_slot == $past(head_slot)));
  // R6
  miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !head_hit) |=> (drop_valid && !drop_reason));
  // R10
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && q_empty) |=> !(fwd_valid || drop_valid));
endmodule

// File: tb/pkt_dispatch_lookup_tb_top.sv
`timescale 1ns/1ps
module pkt_dispatch_lookup_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_valid = 0;
  logic [3:0] cfg_idx = '0;
  logic [7:0] cfg_proto = '0;
  logic [31:0] cfg_addr = '0, cfg_mask = '0;
  logic [15:0] cfg_port = '0;
  logic [2:0] cfg_slot = '0;
  logic hdr_valid = 0, hdr_ready;
  logic [7:0] hdr_proto = '0;
  logic [31:0] hdr_dst_ip = '0;
  logic [15:0] hdr_dst_port = '0;
  logic done_valid = 0;
  logic [7:0] slot_full = '0;
  logic fwd_valid, drop_valid, drop_reason;
  logic [2:0] fwd_slot;

  int checks = 0, fails = 0;

  // bench-side rule table
  bit m_v [16];
  logic [7:0] m_p [16];
  logic [31:0] m_a [16], m_m [16];
  logic [15:0] m_pt [16];
  logic [2:0] m_s [16];
  // bench-side expected outcome queue: {hit, slot}
  logic [3:0] eq [16];
  int eq_wr = 0, eq_rd = 0;

  always #5 clk = ~clk;

  pkt_dispatch_lookup dut_i (
    .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_valid, .cfg_proto, .cfg_addr, .cfg_mask,
    .cfg_port, .cfg_slot, .hdr_valid, .hdr_ready, .hdr_proto, .hdr_dst_ip,
    .hdr_dst_port, .done_valid, .slot_full, .fwd_valid, .fwd_slot, .drop_valid,
    .drop_reason
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // first matching rule from index 0 upward; address compared by masking both sides
  function automatic logic [3:0] model_lookup(logic [7:0] p, logic [31:0] ip, logic [15:0] pt);
    for (int i = 0; i < 16; i++)
      if (m_v[i] && m_p[i] == p && m_pt[i] == pt && (ip & m_m[i]) == (m_a[i] & m_m[i]))
        return {1'b1, m_s[i]};
    return 4'b0;
  endfunction

  task automatic set_cfg(input int idx, input bit v, input logic [7:0] p, input logic [31:0] a,
                         input logic [31:0] m, input logic [15:0] pt, input logic [2:0] s);
    cfg_we = 1; cfg_idx = 4'(idx); cfg_valid = v; cfg_proto = p;
    cfg_addr = a; cfg_mask = m; cfg_port = pt; cfg_slot = s;
  endtask

  task automatic model_cfg(input int idx, input bit v, input logic [7:0] p, input logic [31:0] a,
                           input logic [31:0] m, input logic [15:0] pt, input logic [2:0] s);
    m_v[idx] = v; m_p[idx] = p; m_a[idx] = a; m_m[idx] = m; m_pt[idx] = pt; m_s[idx] = s;
  endtask

  task automatic cfg_write(input int idx, input bit v, input logic [7:0] p, input logic [31:0] a,
                           input logic [31:0] m, input logic [15:0] pt, input logic [2:0] s);
    set_cfg(idx, v, p, a, m, pt, s);
    @(negedge clk);
    cfg_we = 0;
    model_cfg(idx, v, p, a, m, pt, s);
  endtask

  task automatic send_hdr(input logic [7:0] p, input logic [31:0] ip, input logic [15:0] pt);
    hdr_valid = 1; hdr_proto = p; hdr_dst_ip = ip; hdr_dst_port = pt;
    eq[eq_wr % 16] = model_lookup(p, ip, pt);
    eq_wr++;
    @(negedge clk);
    hdr_valid = 0;
  endtask

  task automatic pop_chk(input string tag);
    logic [3:0] e;
    logic [5:0] exp_v, act_v;
    e = eq[eq_rd % 16];
    eq_rd++;
    done_valid = 1;
    @(negedge clk);
    done_valid = 0;
    if (e[3] && !slot_full[e[2:0]]) exp_v = {1'b1, 1'b0, e[2:0], 1'b0};
    else                             exp_v = {1'b0, 1'b1, 3'b0, e[3]};
    act_v = {fwd_valid, drop_valid, fwd_valid ? fwd_slot : 3'b0, drop_valid ? drop_reason : 1'b0};
    chk(act_v == exp_v, tag, 64'(act_v), 64'(exp_v));
  endtask

  task automatic idle_chk(input string tag);
    done_valid = 1;
    @(negedge clk);
    done_valid = 0;
    chk(!fwd_valid && !drop_valid, tag, {62'b0, fwd_valid, drop_valid}, 64'b0);
  endtask

  function automatic logic [31:0] rule_addr(int i);
    return 32'h0A00_0000 | (32'(i) << 8) | ((i % 2 == 1) ? 32'd5 : 32'd0);
  endfunction
  function automatic logic [31:0] rule_mask(int i);
    return (i % 2 == 1) ? 32'hFFFF_FFFF : 32'hFFFF_FF00;
  endfunction
  function automatic logic [7:0] rule_proto(int i);
    return (i % 2 == 1) ? 8'd17 : 8'd6;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model_cfg(i, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(hdr_ready && !fwd_valid && !drop_valid, "R1 reset outputs",
        {61'b0, hdr_ready, fwd_valid, drop_valid}, 64'b100);
    // R10 completion with nothing queued
    idle_chk("R10 done on empty queue");
    // R5 reset leaves all rules invalid, R6 miss drop
    send_hdr(8'd6, 32'h0A00_0000, 16'd1000);
    pop_chk("R5 R6 miss on empty table");

    for (int i = 0; i < 16; i++)
      cfg_write(i, 1, rule_proto(i), rule_addr(i), rule_mask(i), 16'(1000 + i), 3'(i % 8));

    // R2 R3 R6 sweep over every rule
    for (int i = 0; i < 16; i++) begin
      send_hdr(rule_proto(i), rule_addr(i), 16'(1000 + i));
      pop_chk("R2 exact hit");
      send_hdr(rule_proto(i), rule_addr(i) ^ 32'h0000_00A2, 16'(1000 + i));
      pop_chk("R3 subnet host");
      send_hdr(rule_proto(i), rule_addr(i), 16'(1001 + i));
      pop_chk("R6 port mismatch");
      send_hdr(8'd1, rule_addr(i), 16'(1000 + i));
      pop_chk("R6 proto mismatch");
      send_hdr(rule_proto(i), rule_addr(i) ^ 32'h0001_0000, 16'(1000 + i));
      pop_chk("R3 outside subnet");
    end

    // R7 target buffer full
    slot_full = 8'b0000_0010;
    send_hdr(rule_proto(1), rule_addr(1), 16'd1001);
    pop_chk("R7 full slot drop");
    send_hdr(rule_proto(2), rule_addr(2), 16'd1002);
    pop_chk("R7 other slot full");
    slot_full = 8'b1111_1011;
    send_hdr(rule_proto(2), rule_addr(2), 16'd1002);
    pop_chk("R7 only target free");
    slot_full = 8'b0;

    // R4 lowest index wins
    cfg_write(3, 1, 8'd6, 32'h0A00_0000, 32'hFFFF_0000, 16'd1000, 3'd5);
    send_hdr(8'd6, 32'h0A00_0009, 16'd1000);
    pop_chk("R4 lowest index");
    // R5 invalidated rule no longer matches
    cfg_write(0, 0, 8'd6, 32'h0A00_0000, 32'hFFFF_FF00, 16'd1000, 3'd0);
    send_hdr(8'd6, 32'h0A00_0009, 16'd1000);
    pop_chk("R5 invalid rule skipped");

    // R11 write and header on the same edge
    set_cfg(0, 1, 8'd6, 32'h0A00_0000, 32'hFFFF_FF00, 16'd1000, 3'd7);
    send_hdr(8'd6, 32'h0A00_0009, 16'd1000);
    cfg_we = 0;
    model_cfg(0, 1, 8'd6, 32'h0A00_0000, 32'hFFFF_FF00, 16'd1000, 3'd7);
    pop_chk("R11 same-edge write unseen");
    send_hdr(8'd6, 32'h0A00_0009, 16'd1000);
    pop_chk("R11 later header sees write");

    // R9 backpressure, R8 order and lookup time
    send_hdr(rule_proto(5), rule_addr(5), 16'd1005);
    send_hdr(8'd9, 32'h0, 16'd0);
    send_hdr(rule_proto(6), rule_addr(6), 16'd1006);
    send_hdr(rule_proto(2), rule_addr(2), 16'd1002);
    chk(!hdr_ready, "R9 ready low when full", {63'b0, hdr_ready}, 64'b0);
    hdr_valid = 1; hdr_proto = rule_proto(4); hdr_dst_ip = rule_addr(4); hdr_dst_port = 16'd1004;
    @(negedge clk);
    hdr_valid = 0;
    cfg_write(5, 0, 8'd0, 32'h0, 32'h0, 16'd0, 3'd0);
    cfg_write(6, 1, rule_proto(6), rule_addr(6), rule_mask(6), 16'd1006, 3'd1);
    pop_chk("R8 first in order");
    pop_chk("R8 second in order");
    pop_chk("R8 third uses old table");
    pop_chk("R8 fourth in order");
    idle_chk("R9 header while full not queued");
    chk(hdr_ready, "R9 ready after drain", {63'b0, hdr_ready}, 64'b1);

    summary();
    $finish;
  end
endmodule